// File: doc/BRIEF.md
# Sector and Chip Erase Status Engine

This block takes over once a command sequencer has accepted an erase command for a sector-organised non-volatile array. A sector-erase request opens a collection window that lasts a fixed number of clock cycles. Further sector-erase requests that arrive inside that window join the same operation. When the window closes, an erase-busy phase runs for a fixed number of cycles. The block then walks its sector bitmap and issues one fill strobe for each selected sector, so that the array can write all ones into that sector. A chip-erase request selects every sector and goes straight to the busy phase.

While an operation is active, reads come back as a status word instead of array data. In that word, bit 7 reads 0 and bits 6 and 2 flip on every status read. Bit 3 reads 0 while the collection window is still open and 1 after it closes. A suspend request freezes the operation. During suspend, reads of selected sectors still return status, with bit 6 held and bit 2 still flipping, and reads of all other sectors return array data. A resume request restarts the busy counter from the value where it stopped. A busy output tells the sequencer to pass on nothing but suspend and resume.

Top module: `erase_status_engine`

## Requirements
- R1: With no operation active, a read returns the array word presented on `arr_rdata` in the same cycle as `rd_en`, on `rd_data` one cycle later with `rd_valid` high. `busy` is 0 after reset.
- R2: A sector-erase request with no operation active opens a window of WINDOW_CYC cycles. During that window, status reads have bit 3 = 0, and each further sector-erase request adds its sector to the selection.
- R3: After the window closes, status bit 3 reads 1, and sector-erase requests have no effect on the selection.
- R4: In every status word, bit 7 is 0 and all bits other than 7, 6, 3 and 2 are 0.
- R5: While an operation is active and not suspended, bit 6 inverts between successive status reads, whichever sector is read.
- R6: Bit 2 inverts between successive status reads, including reads of a selected sector during suspend.
- R7: While suspended, the busy counter holds its value and `busy` stays 1. A read of a selected sector returns status with bit 6 unchanged between reads. A read of an unselected sector returns array data.
- R8: Resume continues the busy phase from the count reached before suspend. A resume after a suspend that was issued during the window goes to the busy phase with bit 3 = 1.
- R9: At the end of the busy phase, `fill_en` pulses once for each selected sector and for no other sector, with `fill_sect` carrying the index. Reads return array data afterwards.
- R10: A chip-erase request selects all NUM_SECT sectors and skips the window, so bit 3 reads 1 from the first status read.
- R11: `busy` is 1 from the cycle after a request is accepted until the last fill strobe has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sect_req | input | 1 | Sector-erase request pulse |
| sect_idx | input | SW | Sector index for `sect_req` |
| chip_req | input | 1 | Chip-erase request pulse |
| susp_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| rd_en | input | 1 | Read strobe |
| rd_sect | input | SW | Sector index of the read |
| arr_rdata | input | DW | Array word for the current read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DW | Array data or status word |
| fill_en | output | 1 | Write all ones into `fill_sect` |
| fill_sect | output | SW | Sector to fill |
| busy | output | 1 | Operation active |

## Verification
The assertions check the following on every cycle:
- status words never carry bit 7 high;
- the busy counter is frozen outside the busy phase;
- the selection does not change once the window has closed;
- a chip erase selects every sector;
- fill strobes come only from the scan;
- `busy` covers every non-idle state.

Three behaviours can only be shown by the bench scenarios:
- the read-to-read inversions of bits 6 and 2, and the split between selected and unselected sectors under suspend;
- which sectors end up erased while others keep their data;
- that resume continues the count and does not restart it.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WIN  = 3'd1,
    ST_RUN  = 3'd2,
    ST_SUSP = 3'd3,
    ST_FILL = 3'd4
  } erase_st_t;

  // status word bit positions, decoded by software polling loops
  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_WIN  = 3;
  localparam int BIT_ALT  = 2;
endpackage

// File: rtl/erase_cycle_timer.sv
module erase_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run)     cnt <= expire ? '0 : cnt + 1'b1;
  end

  // R7: counter holds while neither running nor cleared (suspend)
  assert_count_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(cnt));
endmodule

// File: rtl/erase_sector_map.sv
module erase_sector_map #(
  parameter int NUM_SECT = 8,
  parameter int SW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_one,
  input  logic [SW-1:0]       set_sect,
  input  logic                set_all,
  input  logic                scan_en,
  output logic [NUM_SECT-1:0] sel,
  output logic                scan_last,
  output logic                fill_en,
  output logic [SW-1:0]       fill_sect
);
  logic [SW-1:0] idx;

  assign scan_last = scan_en && (idx == SW'(NUM_SECT - 1));

  always_ff @(posedge clk) begin
    if (rst || scan_last) sel <= '0;
    else if (set_all)     sel <= '1;
    else if (set_one)     sel[set_sect] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !scan_en) idx <= '0;
    else                 idx <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_en   <= 1'b0;
      fill_sect <= '0;
    end else begin
      fill_en   <= scan_en && sel[idx];
      fill_sect <= idx;
    end
  end

  // R9: fill strobes only follow a scan cycle
  assert_fill_from_scan_R9: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> $past(scan_en));
endmodule

// File: rtl/erase_status_mux.sv
module erase_status_mux #(
  parameter int NUM_SECT = 8,
  parameter int SW = 3,
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [SW-1:0]       rd_sect,
  input  logic [DW-1:0]       arr_rdata,
  input  logic                active,
  input  logic                suspended,
  input  logic                win_open,
  input  logic [NUM_SECT-1:0] sel,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data
);
  import esc_pkg::*;

  logic tog6, tog2, sts_q;
  logic use_status;
  logic [DW-1:0] sts_word;

  always_comb begin
    use_status = active && (!suspended || sel[rd_sect]);
    sts_word = '0;
    sts_word[BIT_POLL] = 1'b0;
    sts_word[BIT_TOG]  = tog6;
    sts_word[BIT_WIN]  = !win_open;
    sts_word[BIT_ALT]  = tog2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      sts_q    <= 1'b0;
      tog6     <= 1'b0;
      tog2     <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        sts_q <= use_status;
        if (use_status) begin
          rd_data <= sts_word;
          tog2    <= !tog2;
          if (!suspended) tog6 <= !tog6;
        end else begin
          rd_data <= arr_rdata;
        end
      end
    end
  end

  // R4: a status word never shows the completion bit high
  assert_poll_low_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && sts_q) |-> !rd_data[BIT_POLL]);
endmodule

// File: rtl/erase_status_engine.sv
module erase_status_engine #(
  parameter int NUM_SECT   = 8,
  parameter int DW         = 16,
  parameter int WINDOW_CYC = 20,
  parameter int ERASE_CYC  = 40,
  parameter int SW         = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sect_req,
  input  logic [SW-1:0] sect_idx,
  input  logic          chip_req,
  input  logic          susp_req,
  input  logic          resume_req,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_sect,
  input  logic [DW-1:0] arr_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          fill_en,
  output logic [SW-1:0] fill_sect,
  output logic          busy
);
  import esc_pkg::*;

  erase_st_t st, nxt;
  logic win_done, win_done_nxt;
  logic win_exp, run_exp, scan_last;
  logic set_one, set_all;
  logic [NUM_SECT-1:0] sel;

  assign set_all = (st == ST_IDLE) && chip_req;
  assign set_one = sect_req && (((st == ST_IDLE) && !chip_req) || (st == ST_WIN));

  always_comb begin
    nxt = st;
    win_done_nxt = win_done;
    unique case (st)
      ST_IDLE: begin
        if (chip_req) begin
          nxt = ST_RUN;
          win_done_nxt = 1'b1;
        end else if (sect_req) begin
          nxt = ST_WIN;
        end
      end
      ST_WIN: begin
        if (susp_req) nxt = ST_SUSP;
        else if (win_exp) begin
          nxt = ST_RUN;
          win_done_nxt = 1'b1;
        end
      end
      ST_RUN: begin
        if (run_exp)       nxt = ST_FILL;
        else if (susp_req) nxt = ST_SUSP;
      end
      ST_SUSP: begin
        if (resume_req) begin
          nxt = ST_RUN;
          win_done_nxt = 1'b1;
        end
      end
      ST_FILL: begin
        if (scan_last) begin
          nxt = ST_IDLE;
          win_done_nxt = 1'b0;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      win_done <= 1'b0;
      busy     <= 1'b0;
    end else begin
      st       <= nxt;
      win_done <= win_done_nxt;
      busy     <= (nxt != ST_IDLE);
    end
  end

  erase_cycle_timer #(.LIMIT(WINDOW_CYC)) u_win_tmr (
    .clk(clk), .rst(rst), .clear(st == ST_IDLE),
    .run(st == ST_WIN), .expire(win_exp));

  erase_cycle_timer #(.LIMIT(ERASE_CYC)) u_run_tmr (
    .clk(clk), .rst(rst), .clear(st == ST_IDLE),
    .run(st == ST_RUN), .expire(run_exp));

  erase_sector_map #(.NUM_SECT(NUM_SECT), .SW(SW)) u_map (
    .clk(clk), .rst(rst), .set_one(set_one), .set_sect(sect_idx),
    .set_all(set_all), .scan_en(st == ST_FILL), .sel(sel),
    .scan_last(scan_last), .fill_en(fill_en), .fill_sect(fill_sect));

  erase_status_mux #(.NUM_SECT(NUM_SECT), .SW(SW), .DW(DW)) u_mux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sect(rd_sect),
    .arr_rdata(arr_rdata), .active(st != ST_IDLE),
    .suspended(st == ST_SUSP),
    .win_open((st == ST_WIN) || ((st == ST_SUSP) && !win_done)),
    .sel(sel), .rd_valid(rd_valid), .rd_data(rd_data));

  // R11: busy covers every non-idle state
  assert_busy_cover_R11: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> busy);

  // R3: late sector requests leave the selection unchanged
  assert_late_req_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RUN) && !run_exp && sect_req) |=> $stable(sel));

  // R10: chip erase selects every sector
  assert_chip_all_R10: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && chip_req) |=> (sel == {NUM_SECT{1'b1}}));
endmodule

// File: tb/sim_erase_status_engine.sv
module sim_erase_status_engine;
  localparam int NS  = 8;
  localparam int DW  = 16;
  localparam int WIN = 20;
  localparam int ERS = 40;
  localparam int SW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sect_req = 0, chip_req = 0, susp_req = 0, resume_req = 0, rd_en = 0;
  logic [SW-1:0] sect_idx = '0, rd_sect = '0;
  logic [DW-1:0] arr_rdata;
  logic rd_valid, fill_en, busy;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] fill_sect;
  logic load_pat = 1'b0;

  logic [DW-1:0] mem [NS];
  int checks = 0, errors = 0, fills = 0, cyc = 0;

  always #10 clk = !clk;

  erase_status_engine #(.NUM_SECT(NS), .DW(DW), .WINDOW_CYC(WIN),
    .ERASE_CYC(ERS)) u0 (
    .clk(clk), .rst(rst), .sect_req(sect_req), .sect_idx(sect_idx),
    .chip_req(chip_req), .susp_req(susp_req), .resume_req(resume_req),
    .rd_en(rd_en), .rd_sect(rd_sect), .arr_rdata(arr_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .fill_en(fill_en),
    .fill_sect(fill_sect), .busy(busy));

  function automatic logic [DW-1:0] pat(input int s);
    return DW'(16'h1000 + s * 16'h0111);
  endfunction

  assign arr_rdata = mem[rd_sect];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load_pat) begin
      for (int i = 0; i < NS; i++) mem[i] <= pat(i);
    end else if (fill_en) begin
      mem[fill_sect] <= '1;
      fills <= fills + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int s, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    rd_sect = SW'(s);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic load();
    @(negedge clk);
    load_pat = 1'b1;
    @(negedge clk);
    load_pat = 1'b0;
  endtask

  task automatic sect(input int s);
    @(negedge clk);
    sect_req = 1'b1;
    sect_idx = SW'(s);
    @(negedge clk);
    sect_req = 1'b0;
  endtask

  task automatic pulse_susp();
    @(negedge clk); susp_req = 1'b1;
    @(negedge clk); susp_req = 1'b0;
  endtask

  task automatic pulse_resume();
    @(negedge clk); resume_req = 1'b1;
    @(negedge clk); resume_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep(input string req, input logic [NS-1:0] erased);
    logic [DW-1:0] d;
    for (int s = 0; s < NS; s++) begin
      rd(s, d);
      chk(req, 32'(d), erased[s] ? 32'h0000FFFF : 32'(pat(s)));
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] a, b, c;
    int f0, t0;
    load_pat = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    load_pat = 1'b0;

    // R1 / R11 reset state
    chk("R11 busy after reset", 32'(busy), 0);
    sweep("R1 idle read", '0);

    // R2 R3 R4 R5 R6 R9: two-sector erase inside window
    f0 = fills;
    sect(2);
    sect(5);
    chk("R11 busy during window", 32'(busy), 1);
    rd(2, a); rd(2, b);
    chk("R2 window bit3", 32'(a[3]), 0);
    chk("R4 bit7 low", 32'(a[7]), 0);
    chk("R4 unused bits", 32'(a & ~16'h00CC), 0);
    chk("R5 bit6 flips", 32'(a[6] ^ b[6]), 1);
    chk("R6 bit2 flips", 32'(a[2] ^ b[2]), 1);
    rd(0, c);
    chk("R5 bit6 flips other sector", 32'(b[6] ^ c[6]), 1);
    repeat (WIN + 2) @(negedge clk);
    rd(2, a);
    chk("R3 bit3 after window", 32'(a[3]), 1);
    wait_idle();
    chk("R9 fill count", 32'(fills - f0), 2);
    sweep("R9 selected sectors erased", 8'b0010_0100);

    // R3: sector request after window ignored
    load();
    f0 = fills;
    sect(1);
    repeat (WIN + 3) @(negedge clk);
    sect(6);
    wait_idle();
    chk("R3 late request fill count", 32'(fills - f0), 1);
    sweep("R3 late request ignored", 8'b0000_0010);

    // R6 R7 R8: suspend in busy phase
    load();
    f0 = fills;
    sect(4);
    repeat (WIN + 10) @(negedge clk);
    pulse_susp();
    rd(4, a); rd(4, b);
    chk("R7 bit6 frozen", 32'(a[6] ^ b[6]), 0);
    chk("R6 bit2 flips in suspend", 32'(a[2] ^ b[2]), 1);
    rd(0, c);
    chk("R7 unselected reads data", 32'(c), 32'(pat(0)));
    repeat (2 * ERS) @(negedge clk);
    chk("R7 busy held", 32'(busy), 1);
    chk("R7 no fill in suspend", 32'(fills - f0), 0);
    pulse_resume();
    t0 = cyc;
    rd(4, a); rd(0, b);
    chk("R8 bit3 after resume", 32'(a[3]), 1);
    chk("R8 bit6 flips after resume", 32'(a[6] ^ b[6]), 1);
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    chk("R8 resume continues count",
        32'((cyc - t0 >= ERS - 15) && (cyc - t0 <= ERS - 10 + NS + 5)), 1);
    repeat (2) @(negedge clk);
    sweep("R9 after suspend", 8'b0001_0000);

    // R8: suspend during window
    load();
    sect(3);
    pulse_susp();
    rd(3, a);
    chk("R8 bit3 in window suspend", 32'(a[3]), 0);
    pulse_resume();
    rd(3, b);
    chk("R8 bit3 after window resume", 32'(b[3]), 1);
    wait_idle();
    sweep("R8 window resume erase", 8'b0000_1000);

    // R10: chip erase
    load();
    f0 = fills;
    @(negedge clk); chip_req = 1'b1;
    @(negedge clk); chip_req = 1'b0;
    rd(7, a); rd(7, b);
    chk("R10 bit3 set", 32'(a[3]), 1);
    chk("R4 bit7 low chip", 32'(a[7]), 0);
    chk("R5 bit6 flips chip", 32'(a[6] ^ b[6]), 1);
    wait_idle();
    chk("R10 fill count", 32'(fills - f0), NS);
    sweep("R10 all erased", '1);
    chk("R11 busy low at end", 32'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule